// File: doc/BRIEF.md
# Direct-Mapped Write-Allocate Cache

This block sits between a processor and main memory and keeps recently used memory lines in a direct-mapped store. The processor issues one word request at a time. Each request carries a 32-bit byte address, a read/write flag and 64-bit write data. The cache answers with a single-cycle response pulse that carries the read data. Memory is split into 32-byte lines of four 64-bit words. Each line can live in only one cache slot, chosen by the index bits of its address. A tag array with a valid flag per slot records which line a slot holds. A data array with one 64-bit word per entry holds the line contents. The data array is addressed by the index followed by the word-select bits.

On a miss, the cache asks main memory for the whole line and takes four beats back in ascending word order. It then looks the request up again, and the lookup now hits. Writes allocate: a write miss first fills the line and then updates the word. Every write is also passed straight to memory (write-through), so no line is ever dirty.

At full size the index is 13 bits (8K lines, 256 KB), the tag is 14 bits and the data array holds 32K words. The default parameters shrink the index to 6 bits for simulation. The offset split stays the same and the tag widens to match.

Back-pressure rules are as follows:
- The request channel is valid/ready, and `cpu_req_ready` is high only while the cache is idle, so at most one request is in flight.
- The fill-request and write-through channels are valid/ready; once raised, valid and payload stay stable until ready is seen.
- The returned fill beats and the response pulse have no ready. The cache always takes a beat, and the processor must take the response in the cycle it appears.

Top module: `dm_cache`

## Requirements
- R1: After reset every slot is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `mem_fill_valid` and `mem_wr_valid` are 0. The first access to any address therefore misses.
- R2: Address bits [2:0] select a byte and are ignored for data selection. Bits [4:3] select one of the four words in a line. Bits [OFFSET_W+INDEX_W-1:5] are the index, and the remaining high bits are the tag.
- R3: On a read hit, `cpu_rsp_valid` is high for exactly one cycle, starting on the first rising edge after the edge that accepts the request. `cpu_rsp_rdata` is the cached word, and no fill request is made.
- R4: On a read miss, exactly one fill request is raised. Its `mem_fill_addr` is the request address with bits [4:0] cleared. The four beats that follow are stored as words 0,1,2,3 in that order, and the response then returns the requested word.
- R5: A write miss fills the line before writing. After it, a read of the written word returns the new data, and reads of the other words of that line return the filled data.
- R6: Every write raises exactly one write-through request, with `mem_wr_addr` equal to the request address and `mem_wr_data` equal to the write data. It is held until `mem_wr_ready`, and the write response comes after that handshake. Reads raise none.
- R7: Two addresses with the same index and different tags evict each other, so alternating between them misses every time.
- R8: `cpu_req_ready` is 0 from acceptance until the response has been given. A pending fill or write-through request keeps its valid and payload stable until its ready is seen. Fill and write-through requests never overlap.
- R9: A hit requires both the slot's valid flag and a tag match. A word of a line that has been filled hits, and a word whose line has not been filled misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache idle and accepting a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address of the request |
| cpu_req_wdata | input | DATA_W | Write data (full word) |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data (meaningful for reads only) |
| mem_fill_valid | output | 1 | Line fill request |
| mem_fill_ready | input | 1 | Memory accepts the fill request |
| mem_fill_addr | output | ADDR_W | Line-aligned fill address |
| mem_beat_valid | input | 1 | Fill beat present |
| mem_beat_data | input | DATA_W | Fill beat data, word 0 first |
| mem_wr_valid | output | 1 | Write-through request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Write-through byte address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
A read hit responds one edge after it is accepted. The bench stamps the acceptance cycle when it drives a request and checks that exact distance when the response pulse is seen at a falling edge. Misses and writes have a latency set by the bench's own memory delays. For those, the monitor instead checks that exactly one fill, or exactly one write-through, happened between acceptance and response, and it checks the data against a bench-side memory image and slot table. Fill beats are presented one per cycle right after the handshake. Expected data is computed at request time, after the previous response, so write-through updates to the image are already in place.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_REQ,
    ST_FILL,
    ST_WTHRU,
    ST_RESP
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 6,
  parameter int TAG_W   = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] lk_index,
  output logic               lk_valid,
  output logic [TAG_W-1:0]   lk_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_index] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_index] <= wr_tag;
  end

  assign lk_valid = valid_q[lk_index];
  assign lk_tag   = tag_q[lk_index];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 6,
  localparam int BYTE_W  = $clog2(DATA_W / 8),
  localparam int WSEL_W  = OFFSET_W - BYTE_W,
  localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W,
  localparam int DADDR_W = INDEX_W + WSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_write,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_rsp_valid,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  output logic               mem_fill_valid,
  input  logic               mem_fill_ready,
  output logic [ADDR_W-1:0]  mem_fill_addr,
  input  logic               mem_beat_valid,
  input  logic [DATA_W-1:0]  mem_beat_data,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  output logic [INDEX_W-1:0] tag_index,
  input  logic               tag_valid,
  input  logic [TAG_W-1:0]   tag_rd,
  output logic               tag_we,
  output logic [TAG_W-1:0]   tag_wr,
  output logic               ram_we,
  output logic [DADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0]  ram_wdata,
  output logic [DADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0]  ram_rdata
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = '1;

  dmc_state_e        state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_q;
  logic [WSEL_W-1:0] beat_q;

  logic [INDEX_W-1:0] idx;
  logic [WSEL_W-1:0]  word;
  logic               hit;
  logic               fill_beat;

  assign idx       = addr_q[OFFSET_W +: INDEX_W];
  assign word      = addr_q[BYTE_W +: WSEL_W];
  assign tag_wr    = addr_q[ADDR_W-1 -: TAG_W];
  assign hit       = tag_valid && (tag_rd == tag_wr);
  assign fill_beat = (state_q == ST_FILL) && mem_beat_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_req_valid) begin
          wr_q    <= cpu_req_write;
          addr_q  <= cpu_req_addr;
          wdata_q <= cpu_req_wdata;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (!hit)      state_q <= ST_FILL_REQ;
          else if (wr_q) state_q <= ST_WTHRU;
          else begin
            rsp_q   <= ram_rdata;
            state_q <= ST_RESP;
          end
        end
        ST_FILL_REQ: if (mem_fill_ready) state_q <= ST_FILL;
        ST_FILL: if (mem_beat_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_q <= ST_LOOKUP;
        end
        ST_WTHRU: if (mem_wr_ready) state_q <= ST_RESP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready  = (state_q == ST_IDLE);
  assign cpu_rsp_valid  = (state_q == ST_RESP);
  assign cpu_rsp_rdata  = rsp_q;
  assign mem_fill_valid = (state_q == ST_FILL_REQ);
  assign mem_fill_addr  = {addr_q[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
  assign mem_wr_valid   = (state_q == ST_WTHRU);
  assign mem_wr_addr    = addr_q;
  assign mem_wr_data    = wdata_q;

  assign tag_index = idx;
  assign tag_we    = fill_beat && (beat_q == LAST_BEAT);
  assign ram_we    = fill_beat || ((state_q == ST_LOOKUP) && hit && wr_q);
  assign ram_waddr = (state_q == ST_FILL) ? {idx, beat_q} : {idx, word};
  assign ram_wdata = (state_q == ST_FILL) ? mem_beat_data : wdata_q;
  assign ram_raddr = {idx, word};
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_fill_valid,
  input  logic              mem_fill_ready,
  output logic [ADDR_W-1:0] mem_fill_addr,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WSEL_W  = OFFSET_W - BYTE_W;
  localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W;
  localparam int DADDR_W = INDEX_W + WSEL_W;

  logic [INDEX_W-1:0] tag_index;
  logic               tag_valid;
  logic [TAG_W-1:0]   tag_rd;
  logic               tag_we;
  logic [TAG_W-1:0]   tag_wr;
  logic               ram_we;
  logic [DADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0]  ram_wdata;
  logic [DADDR_W-1:0] ram_raddr;
  logic [DATA_W-1:0]  ram_rdata;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_fill_valid(mem_fill_valid), .mem_fill_ready(mem_fill_ready),
    .mem_fill_addr(mem_fill_addr), .mem_beat_valid(mem_beat_valid),
    .mem_beat_data(mem_beat_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .tag_index(tag_index), .tag_valid(tag_valid), .tag_rd(tag_rd),
    .tag_we(tag_we), .tag_wr(tag_wr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
  );

  dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_index(tag_index), .lk_valid(tag_valid), .lk_tag(tag_rd),
    .wr_en(tag_we), .wr_index(tag_index), .wr_tag(tag_wr)
  );

  dmc_data_store #(.AW(DADDR_W), .DW(DATA_W)) u_data (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int OFFSET_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_fill_valid,
  input logic              mem_fill_ready,
  input logic [ADDR_W-1:0] mem_fill_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data
);
  // R4: fill requests are line aligned
  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fill_valid |-> (mem_fill_addr[OFFSET_W-1:0] == '0));

  // R8: a pending fill request holds
  p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fill_valid && !mem_fill_ready) |=> (mem_fill_valid && $stable(mem_fill_addr)));

  // R6: a pending write-through request holds
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R8: no overlap between memory-side requests
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_fill_valid && mem_wr_valid));

  // R8: no new request accepted while busy
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid || mem_fill_valid || mem_wr_valid) |-> !cpu_req_ready);

  // R3: the response is a single-cycle pulse
  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);
endmodule

bind dm_cache dm_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET_W(OFFSET_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .mem_fill_valid(mem_fill_valid),
  .mem_fill_ready(mem_fill_ready), .mem_fill_addr(mem_fill_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/dm_cache_test.sv
`timescale 1ns/1ps
module dm_cache_test;
  localparam int IDX_W = 6;
  localparam int OFF_W = 5;

  typedef struct {
    logic        wr;
    logic [31:0] addr;
    logic [63:0] data;
    logic        hit;
    int          acc;
    int          fills;
    int          wrs;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [63:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [63:0] cpu_rsp_rdata;
  logic        mem_fill_valid;
  logic        mem_fill_ready = 1'b0;
  logic [31:0] mem_fill_addr;
  logic        mem_beat_valid = 1'b0;
  logic [63:0] mem_beat_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr;
  logic [63:0] mem_wr_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fill_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] last_wr_addr;
  logic [63:0] last_wr_data;
  logic [31:0] cur_addr;
  bit done = 0;

  item_t sb[$];
  logic [63:0] image [logic [31:0]];
  bit          bvalid [1 << IDX_W];
  logic [31:0] btag   [1 << IDX_W];

  dm_cache #(.INDEX_W(IDX_W)) uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:3], 3'b000};
    if (image.exists(w)) return image[w];
    return {w ^ 32'hA5A5_0000, ~w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [31:0] a, input logic [63:0] d,
                        input string tag);
    item_t it;
    int idx;
    @(negedge clk);
    while (!cpu_req_ready || sb.size() != 0) @(negedge clk);
    idx = int'(a[OFF_W +: IDX_W]);
    it.wr = wr; it.addr = a; it.data = wr ? d : mem_word(a);
    it.hit = bvalid[idx] && btag[idx] == (a >> (OFF_W + IDX_W));
    it.acc = cyc + 1; it.fills = fill_cnt; it.wrs = wr_cnt; it.tag = tag;
    bvalid[idx] = 1'b1;
    btag[idx] = a >> (OFF_W + IDX_W);
    cur_addr = a;
    sb.push_back(it);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (cpu_rsp_valid) begin
        item_t it;
        if (sb.size() == 0) begin
          check(0, "R8 unexpected response", 64'd1, 64'd0);
        end else begin
          it = sb.pop_front();
          check((fill_cnt - it.fills) == (it.hit ? 0 : 1), {it.tag, " fill count (R9)"},
                64'(fill_cnt - it.fills), 64'(it.hit ? 0 : 1));
          if (it.hit && !it.wr)
            check((cyc - it.acc) == 1, {it.tag, " hit latency R3"},
                  64'(cyc - it.acc), 64'd1);
          if (it.wr) begin
            check((wr_cnt - it.wrs) == 1, {it.tag, " write-through R6"},
                  64'(wr_cnt - it.wrs), 64'd1);
            check(last_wr_addr == it.addr && last_wr_data == it.data,
                  {it.tag, " write-through payload R6"}, last_wr_data, it.data);
          end else begin
            check((wr_cnt - it.wrs) == 0, {it.tag, " read no write R6"},
                  64'(wr_cnt - it.wrs), 64'd0);
            check(cpu_rsp_rdata == it.data, {it.tag, " read data"},
                  cpu_rsp_rdata, it.data);
          end
        end
      end
    end
  end

  // fill responder (R4, R8)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_fill_valid) begin
        logic [31:0] la;
        for (int k = 0; k < (fill_cnt % 3); k++) @(negedge clk);
        la = mem_fill_addr;
        check(la == {cur_addr[31:5], 5'd0}, "R4 fill address", 64'(la),
              64'({cur_addr[31:5], 5'd0}));
        check(cpu_req_ready == 1'b0, "R8 busy during fill", 64'(cpu_req_ready), 64'd0);
        mem_fill_ready = 1'b1;
        fill_cnt++;
        @(negedge clk);
        mem_fill_ready = 1'b0;
        for (int b = 0; b < 4; b++) begin
          mem_beat_valid = 1'b1;
          mem_beat_data = mem_word(la + 32'(b * 8));
          @(negedge clk);
        end
        mem_beat_valid = 1'b0;
      end
    end
  end

  // write-through responder (R6)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_wr_valid) begin
        for (int k = 0; k < (wr_cnt % 2) + 1; k++) @(negedge clk);
        last_wr_addr = mem_wr_addr;
        last_wr_data = mem_wr_data;
        image[{mem_wr_addr[31:3], 3'b000}] = mem_wr_data;
        mem_wr_ready = 1'b1;
        wr_cnt++;
        @(negedge clk);
        mem_wr_ready = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << IDX_W); i++) begin bvalid[i] = 0; btag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R1 ready after reset", 64'(cpu_req_ready), 64'd1);
    check(cpu_rsp_valid == 1'b0, "R1 no response after reset", 64'(cpu_rsp_valid), 64'd0);
    check(mem_fill_valid == 1'b0, "R1 no fill after reset", 64'(mem_fill_valid), 64'd0);
    check(mem_wr_valid == 1'b0, "R1 no write after reset", 64'(mem_wr_valid), 64'd0);

    do_req(0, 32'h0000_1000, '0, "R1 R4 first read miss");
    do_req(0, 32'h0000_1008, '0, "R3 hit word1");
    do_req(0, 32'h0000_101B, '0, "R2 byte bits ignored word3");
    do_req(0, 32'h0000_1010, '0, "R2 word2");
    do_req(1, 32'h0000_1010, 64'h1122_3344_5566_7788, "R6 write hit");
    do_req(0, 32'h0000_1010, '0, "R6 read after write hit");
    do_req(0, 32'h0000_1800, '0, "R7 conflict miss");
    do_req(0, 32'h0000_1000, '0, "R7 evicted again");
    do_req(0, 32'h0000_1808, '0, "R7 evicted third");
    do_req(1, 32'h0000_2048, 64'hDEAD_BEEF_0BAD_F00D, "R5 write miss");
    do_req(0, 32'h0000_2048, '0, "R5 written word");
    do_req(0, 32'h0000_2040, '0, "R5 filled neighbour");
    do_req(0, 32'h0000_2060, '0, "R9 other line misses");
    do_req(0, 32'hFFFF_FFE0, '0, "R2 top address miss");
    do_req(0, 32'hFFFF_FFF8, '0, "R9 top address hit");
    do_req(1, 32'hFFFF_FFF8, 64'h0F0F_0F0F_F0F0_F0F0, "R6 write hit top");
    do_req(0, 32'hFFFF_FFF8, '0, "R6 readback top");

    @(negedge clk);
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule